// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block paints a 32 by 32 two-colour pointer over a raster pixel stream. Each pixel arrives with its screen coordinates and a base colour; one clock later the block emits either that base colour or one of two overlay colours supplied from an external colour table. The two overlay colours are the table's top pair of entries: the foreground colour stands for entry 259 and the background colour for entry 258.

Software programs the pointer through a 32-bit word register port: one packed position word, 32 row shape (mask) words, 32 row colour-select (data) words and a general-purpose miscellaneous word. Within a row, a mask bit of 0 leaves the screen pixel visible and a mask bit of 1 replaces it, with the data bit choosing foreground or background. The pointer is clipped at the right edge of the active area. If its X origin is at or beyond that edge it is not drawn at all.

The pixel path is purely combinational up to a single output register stage. The select decision is an enumerated choice (`PICK_BASE`, `PICK_BG`, `PICK_FG`) taken once per pixel. There are no other states: `PICK_BASE` is chosen for any pixel outside the pointer square or outside the active width. `PICK_BG` is chosen where the mask bit is 1 and the data bit is 0, and `PICK_FG` where both bits are 1.

Top module: `cursor_overlay`

## Requirements
- R1: A write to word offset 0x8FC loads the pointer X origin from bits 31:16 and the Y origin from bits 15:0.
- R2: Writes to offsets 0x900 + 4*r (r = 0..31) load mask row r, and writes to offsets 0x980 + 4*r load data row r.
- R3: Pointer column c (0 = leftmost) is controlled by bit 31-c of its row words.
- R4: Where the mask bit is 0 the base colour is output. Where it is 1, `ovl_fg_rgb` (entry 259) is output when the data bit is 1, and `ovl_bg_rgb` (entry 258) when it is 0.
- R5: The pointer covers rows Y..Y+31 and columns X..X+31, computed without wrap-around at the top of the coordinate range. Pixels outside that square output the base colour.
- R6: The pointer is drawn only when X < ACTIVE_W. Pixels with x >= ACTIVE_W always output the base colour, so the pointer is clipped at the right edge.
- R7: After reset, X and Y are both 0xF000, all mask rows are zero and the miscellaneous word is zero, so no pixel is altered.
- R8: A read returns data on the cycle after the read strobe. A read of offset 0x818 returns the stored miscellaneous word with bit 25 forced to 1, and every other offset reads as zero.
- R9: `out_valid` and `out_rgb` follow `pix_valid` and the corresponding pixel by exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Byte offset of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel row |
| pix_rgb | input | PIX_W | Base colour of the pixel |
| ovl_bg_rgb | input | PIX_W | Overlay colour for mask 1, data 0 (entry 258) |
| ovl_fg_rgb | input | PIX_W | Overlay colour for mask 1, data 1 (entry 259) |
| out_valid | output | 1 | Output pixel qualifier |
| out_rgb | output | PIX_W | Output colour |

## Verification
Every pixel of a 64-column window is swept over bands of rows around several pointer placements. The placements are: one fully inside the active area, one straddling the right edge, one with X exactly equal to the active width, and one whose rows run into the top of the coordinate range. The first placement separates the mask, data and bit-order logic. The second and third separate the pixel-edge clip from the origin test. The last exposes any modular wrap in the row test. The row patterns are arithmetic and set both bit 31 and bit 0 in every mask row, so a reversed bit order or a swapped mask and data bank shows up. A sweep immediately after reset and a set of register reads confirm the reset values and the read masking.

// File: rtl/cursor_overlay_pkg.sv
package cursor_overlay_pkg;
    localparam int CUR_N = 32;                  // pointer is CUR_N x CUR_N, one word per row
    localparam int IDX_W = $clog2(CUR_N);

    localparam int OFF_MISC = 'h818;
    localparam int OFF_POS  = 'h8FC;
    localparam int OFF_MASK = 'h900;
    localparam int OFF_BITS = 'h980;
    localparam int MISC_ONE_BIT = 25;

    typedef enum logic [1:0] {
        PICK_BASE = 2'd0,
        PICK_BG   = 2'd1,
        PICK_FG   = 2'd2
    } pick_t;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
    import cursor_overlay_pkg::*;
#(
    parameter int AW      = 12,
    parameter int COORD_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [IDX_W-1:0]   row_sel,
    output logic [CUR_N-1:0]   mask_row,
    output logic [CUR_N-1:0]   bits_row,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y
);
    localparam logic [AW-1:0] A_MISC     = AW'(OFF_MISC);
    localparam logic [AW-1:0] A_POS      = AW'(OFF_POS);
    localparam logic [AW-1:0] A_MASK_LO  = AW'(OFF_MASK);
    localparam logic [AW-1:0] A_MASK_HI  = AW'(OFF_MASK + 4 * CUR_N);
    localparam logic [AW-1:0] A_BITS_LO  = AW'(OFF_BITS);
    localparam logic [AW-1:0] A_BITS_HI  = AW'(OFF_BITS + 4 * CUR_N);
    localparam logic [COORD_W-1:0] PARK  = COORD_W'('hF000);

    logic [CUR_N-1:0]   mask_q [CUR_N];
    logic [CUR_N-1:0]   bits_q [CUR_N];
    logic [31:0]        misc_q;
    logic               sel_pos, sel_misc, sel_mask, sel_bits;
    logic [AW-1:0]      mask_off, bits_off;
    logic [IDX_W-1:0]   mask_idx, bits_idx;

    always_comb begin
        sel_pos  = (reg_addr == A_POS);
        sel_misc = (reg_addr == A_MISC);
        sel_mask = (reg_addr >= A_MASK_LO) && (reg_addr < A_MASK_HI);
        sel_bits = (reg_addr >= A_BITS_LO) && (reg_addr < A_BITS_HI);
        mask_off = reg_addr - A_MASK_LO;
        bits_off = reg_addr - A_BITS_LO;
        mask_idx = mask_off[IDX_W+1:2];
        bits_idx = bits_off[IDX_W+1:2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_x  <= PARK;
            cur_y  <= PARK;
            misc_q <= '0;
        end else if (reg_wr) begin
            if (sel_pos) begin
                cur_x <= reg_wdata[31:16];
                cur_y <= reg_wdata[15:0];
            end
            if (sel_misc) begin
                misc_q <= reg_wdata;
            end
        end
    end

    for (genvar r = 0; r < CUR_N; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[r] <= '0;
                bits_q[r] <= '0;
            end else if (reg_wr) begin
                if (sel_mask && mask_idx == IDX_W'(r)) begin
                    mask_q[r] <= reg_wdata[CUR_N-1:0];
                end
                if (sel_bits && bits_idx == IDX_W'(r)) begin
                    bits_q[r] <= reg_wdata[CUR_N-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (reg_rd && sel_misc) begin
            reg_rdata <= misc_q | (32'd1 << MISC_ONE_BIT);
        end else begin
            reg_rdata <= '0;
        end
    end

    always_comb begin
        mask_row = mask_q[row_sel];
        bits_row = bits_q[row_sel];
    end
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
    import cursor_overlay_pkg::*;
#(
    parameter int COORD_W  = 16,
    parameter int ACTIVE_W = 1024
) (
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [COORD_W-1:0] cur_x,
    input  logic [COORD_W-1:0] cur_y,
    output logic [IDX_W-1:0]   row_sel,
    input  logic [CUR_N-1:0]   mask_row,
    input  logic [CUR_N-1:0]   bits_row,
    output pick_t              pick
);
    localparam logic [COORD_W:0] SPAN = (COORD_W+1)'(CUR_N);
    localparam logic [31:0]      LIMIT = 32'(ACTIVE_W);

    logic [COORD_W:0]  dx, dy;
    logic              in_rows, in_cols, shown;
    logic [IDX_W-1:0]  col;
    logic [IDX_W-1:0]  bit_pos;

    always_comb begin
        dx       = {1'b0, pix_x} - {1'b0, cur_x};
        dy       = {1'b0, pix_y} - {1'b0, cur_y};
        in_rows  = (pix_y >= cur_y) && (dy < SPAN);
        in_cols  = (pix_x >= cur_x) && (dx < SPAN);
        shown    = (32'(cur_x) < LIMIT) && (32'(pix_x) < LIMIT);
        row_sel  = dy[IDX_W-1:0];
        col      = dx[IDX_W-1:0];
        bit_pos  = IDX_W'(CUR_N - 1) - col;
        pick     = PICK_BASE;
        if (in_rows && in_cols && shown && mask_row[bit_pos]) begin
            pick = bits_row[bit_pos] ? PICK_FG : PICK_BG;
        end
    end
endmodule

// File: rtl/cursor_mux.sv
module cursor_mux
    import cursor_overlay_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_rgb,
    input  logic [PIX_W-1:0] ovl_bg_rgb,
    input  logic [PIX_W-1:0] ovl_fg_rgb,
    input  pick_t            pick,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_rgb
);
    logic [PIX_W-1:0] chosen;

    always_comb begin
        unique case (pick)
            PICK_BG:   chosen = ovl_bg_rgb;
            PICK_FG:   chosen = ovl_fg_rgb;
            default:   chosen = pix_rgb;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_rgb   <= '0;
        end else begin
            out_valid <= pix_valid;
            out_rgb   <= chosen;
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
    import cursor_overlay_pkg::*;
#(
    parameter int AW       = 12,
    parameter int COORD_W  = 16,
    parameter int PIX_W    = 24,
    parameter int ACTIVE_W = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               pix_valid,
    input  logic [COORD_W-1:0] pix_x,
    input  logic [COORD_W-1:0] pix_y,
    input  logic [PIX_W-1:0]   pix_rgb,
    input  logic [PIX_W-1:0]   ovl_bg_rgb,
    input  logic [PIX_W-1:0]   ovl_fg_rgb,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_rgb
);
    logic [IDX_W-1:0]   row_sel;
    logic [CUR_N-1:0]   mask_row, bits_row;
    logic [COORD_W-1:0] cur_x, cur_y;
    pick_t              pick;

    cursor_regs #(.AW(AW), .COORD_W(COORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .row_sel(row_sel), .mask_row(mask_row), .bits_row(bits_row),
        .cur_x(cur_x), .cur_y(cur_y)
    );

    cursor_hit #(.COORD_W(COORD_W), .ACTIVE_W(ACTIVE_W)) u_hit (
        .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
        .row_sel(row_sel), .mask_row(mask_row), .bits_row(bits_row),
        .pick(pick)
    );

    cursor_mux #(.PIX_W(PIX_W)) u_mux (
        .clk(clk), .rst_n(rst_n),
        .pix_valid(pix_valid), .pix_rgb(pix_rgb),
        .ovl_bg_rgb(ovl_bg_rgb), .ovl_fg_rgb(ovl_fg_rgb),
        .pick(pick), .out_valid(out_valid), .out_rgb(out_rgb)
    );
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
    import cursor_overlay_pkg::*;
#(
    parameter int AW       = 12,
    parameter int COORD_W  = 16,
    parameter int PIX_W    = 24,
    parameter int ACTIVE_W = 1024
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_rd,
    input logic [AW-1:0]      reg_addr,
    input logic [31:0]        reg_rdata,
    input logic               pix_valid,
    input logic [COORD_W-1:0] pix_x,
    input logic [PIX_W-1:0]   pix_rgb,
    input logic [PIX_W-1:0]   ovl_bg_rgb,
    input logic [PIX_W-1:0]   ovl_fg_rgb,
    input logic               out_valid,
    input logic [PIX_W-1:0]   out_rgb
);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid);
    assert_idle_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> !out_valid);
    assert_right_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && 32'(pix_x) >= 32'(ACTIVE_W)) |=> (out_rgb == $past(pix_rgb)));
    assert_zero_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr != AW'(OFF_MISC)) |=> (reg_rdata == 32'd0));
    assert_misc_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == AW'(OFF_MISC)) |=> reg_rdata[MISC_ONE_BIT]);
    assert_colour_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> (out_rgb == $past(pix_rgb) || out_rgb == $past(ovl_bg_rgb)
                       || out_rgb == $past(ovl_fg_rgb)));
endmodule

bind cursor_overlay cursor_overlay_chk #(
    .AW(AW), .COORD_W(COORD_W), .PIX_W(PIX_W), .ACTIVE_W(ACTIVE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_rgb(pix_rgb), .ovl_bg_rgb(ovl_bg_rgb), .ovl_fg_rgb(ovl_fg_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/sim_cursor_overlay.sv
module sim_cursor_overlay;
    localparam int AW = 12;
    localparam int CW = 16;
    localparam int PW = 24;
    localparam int WIDTH = 48;
    localparam logic [PW-1:0] BG = 24'h5A0F3C;
    localparam logic [PW-1:0] FG = 24'hA5A5A5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          pix_valid = 1'b0;
    logic [CW-1:0] pix_x = '0, pix_y = '0;
    logic [PW-1:0] pix_rgb = '0;
    logic          out_valid;
    logic [PW-1:0] out_rgb;

    int checks = 0;
    int errors = 0;
    int cx = 'hF000, cy = 'hF000;
    logic [31:0] mrow [32];
    logic [31:0] drow [32];

    always #4 clk = ~clk;

    cursor_overlay #(.AW(AW), .COORD_W(CW), .PIX_W(PW), .ACTIVE_W(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb),
        .ovl_bg_rgb(BG), .ovl_fg_rgb(FG), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mpat(input int r);
        return 32'h8000_0001 | (32'h2545_F491 * 32'(r + 1));
    endfunction
    function automatic logic [31:0] dpat(input int r);
        return (32'h9E37_79B9 * 32'(r + 3)) ^ (32'(r) << 7);
    endfunction
    function automatic logic [PW-1:0] base(input int x, input int y);
        return {x[7:0], y[7:0], 8'hC3};
    endfunction

    // R3 R4 R5 R6 model
    function automatic logic [PW-1:0] expect_pix(input int x, input int y);
        int r, c;
        if (cx >= WIDTH || x >= WIDTH) return base(x, y);
        if (y < cy || y - cy >= 32 || x < cx || x - cx >= 32) return base(x, y);
        r = y - cy;
        c = x - cx;
        if (!mrow[r][31-c]) return base(x, y);
        return drow[r][31-c] ? FG : BG;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = AW'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, reg_rdata, exp);
    endtask

    task automatic sweep(input int y0, input int y1, input string req);
        @(negedge clk);
        for (int y = y0; y <= y1; y++) begin
            for (int x = 0; x < 64; x++) begin
                pix_valid = 1'b1; pix_x = CW'(x); pix_y = CW'(y); pix_rgb = base(x, y);
                @(negedge clk);
                check({req, " R9 valid"}, 32'(out_valid), 32'd1);
                check(req, 32'(out_rgb), 32'(expect_pix(x, y)));
            end
        end
        pix_valid = 1'b0;
        @(negedge clk);
        check("R9 idle", 32'(out_valid), 32'd0);
    endtask

    task automatic place(input int x, input int y);
        cx = x; cy = y;
        wr('h8FC, {x[15:0], y[15:0]});
    endtask

    initial begin
        for (int r = 0; r < 32; r++) begin mrow[r] = '0; drow[r] = '0; end
        repeat (3) @(negedge clk);
        check("R7 reset valid", 32'(out_valid), 32'd0);
        check("R7 reset rdata", reg_rdata, 32'd0);
        rst_n = 1'b1;
        rd('h818, 32'h0200_0000, "R7 R8 misc after reset");
        sweep(0, 3, "R7 parked pointer");

        for (int r = 0; r < 32; r++) begin
            wr('h900 + 4 * r, mpat(r)); mrow[r] = mpat(r);
            wr('h980 + 4 * r, dpat(r)); drow[r] = dpat(r);
        end
        rd('h900, 32'd0, "R8 mask offset reads zero");
        rd('h8FC, 32'd0, "R8 position offset reads zero");
        wr('h818, 32'h8000_1234);
        rd('h818, 32'h8200_1234, "R8 misc forced bit");
        wr('h818, 32'h0200_0001);
        rd('h818, 32'h0200_0001, "R8 misc already set");
        rd('h81C, 32'd0, "R8 neighbour offset");

        place(5, 3);
        sweep(0, 37, "R1 R2 R3 R4 R5 inside");
        place(30, 10);
        sweep(8, 43, "R6 right clip");
        place(WIDTH, 0);
        sweep(0, 33, "R6 origin at width");
        place(WIDTH - 1, 2);
        sweep(1, 34, "R6 origin at last column");
        place(0, 'hFFFA);
        sweep('hFFF8, 'hFFFF, "R5 top of range");
        sweep(0, 2, "R5 no wrap");

        wr('h900 + 4 * 7, 32'h0);   mrow[7] = 32'h0;
        wr('h980 + 4 * 7, 32'hFFFF_FFFF); drow[7] = 32'hFFFF_FFFF;
        place(3, 0);
        sweep(6, 8, "R4 R2 cleared mask row");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule